// File: doc/BRIEF.md
# Frame Buffer Write Port Front-End

This block sits between a client and the memory side of a frame buffer write port. The client pushes 32-bit command words into a command queue. It pushes write data words into a separate data queue. The memory side pops command words one at a time. It drains write data in bursts of up to `BURST_LEN` (32) words. Each queued command word carries a tag that marks the final word of its command. Each data word carries a tag that marks the end of a short burst.

A command is normally `CMD_WORDS` words long. A non-2D transfer may stop early when the client raises the end strobe on the second word. The client sees status flags for full, almost-full and idle. The client has two ways to clear the data queue. A flush empties the data queue and leaves the queued commands alone. A reset empties the data queue and also discards the command that is in progress. Pushes into a full queue are lost and set a sticky overflow flag. Everything runs on one clock, with a synchronous active-high reset.

Top module: `fbwr_front`

## Requirements
- R1: After reset, `cmdIdle` is 1. `cmdFull`, `cmdAlmostFull`, `cmdOutValid`, `rdReady`, `cmdOverflow` and `wdOverflow` are all 0.
- R2: Every cycle with `cmdWrite` high and the queue not full stores `cmdData`. Words leave on `cmdOutData` in arrival order, one per `cmdOutPop` while `cmdOutValid` is high.
- R3: `cmdFull` is 1 exactly when `CMD_DEPTH` words are queued. `cmdAlmostFull` is 1 exactly when at least `AFULL_CNT` words are queued.
- R4: `cmdIdle` is 1 only when no command word is queued, no command is partly written, and no discard is pending.
- R5: Command words are counted from index 0. A word is tagged last (`cmdOutLast` = 1 at the queue head) when its index is `CMD_WORDS`-1, or when its index is 1 and `cmdEnd` is high. `cmdEnd` on any other index has no effect.
- R6: `rdReady` rises when at least `BURST_LEN` data words are queued or a queued word carries the end-of-burst tag. Once a burst has started, `rdReady` stays high until the burst ends. `rdLast` marks the word that ends the burst: either the tagged word or the `BURST_LEN`-th word of the burst, whichever comes first.
- R7: A one-cycle `wdFlush` empties the data queue and leaves every queued command word in place.
- R8: A one-cycle `wdReset` empties the data queue and removes the head command, up to and including its last-tagged word. If no complete command is queued, it empties the command queue, and later command words are discarded up to and including the next word that would be tagged last.
- R9: `wdByteEn` has no effect: stored data is returned unchanged whatever its value.
- R10: A push into a full queue is lost and sets a sticky flag (`cmdOverflow` for the command queue, `wdOverflow` for the data queue). The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdData | input | 32 | Command word |
| cmdWrite | input | 1 | Push command word |
| cmdEnd | input | 1 | End command early (honoured on index 1 only) |
| cmdFull | output | 1 | Command queue full |
| cmdAlmostFull | output | 1 | Command occupancy at or above threshold |
| cmdIdle | output | 1 | No command queued or in progress |
| wdReset | input | 1 | Clear data queue and drop current command |
| wdFlush | input | 1 | Clear data queue, keep commands |
| wdWrite | input | 1 | Push data word |
| wdData | input | DATA_W | Write data word |
| wdByteEn | input | DATA_W/8 | Byte enables (ignored) |
| wdEndBurst | input | 1 | Tag this word as end of burst |
| cmdOutValid | output | 1 | Command word available |
| cmdOutData | output | 32 | Head command word |
| cmdOutLast | output | 1 | Head word ends its command |
| cmdOutPop | input | 1 | Memory side takes head command word |
| rdReady | output | 1 | A burst may be drained |
| rdData | output | DATA_W | Head data word |
| rdLast | output | 1 | Head data word ends the burst |
| rdPop | input | 1 | Memory side takes head data word |
| cmdOverflow | output | 1 | Sticky: command push lost |
| wdOverflow | output | 1 | Sticky: data push lost |

## Verification
The bench builds the block with `CMD_DEPTH` = 8, `AFULL_CNT` = 6, `CMD_WORDS` = 4, `DATA_DEPTH` = 64 and `BURST_LEN` = 32. With an 8-entry command queue, the almost-full threshold, the full state and an overflow can all be reached within a couple of commands. Mixed full-length and early-ended commands are then enough to fill the queue. A 64-entry data queue holds two full bursts, so the bench can exercise a full 32-word burst, a short tagged burst and a data overflow. The same setup covers clearing a data queue that holds a partial burst, with complete or incomplete commands queued.

// File: rtl/fbwr_pkg.sv
package fbwr_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic cmdPush;
    logic cmdTag;
    logic cmdPop;
    logic cmdDrop;
    logic dataPush;
    logic dataPop;
    logic dataClear;
  } strobe_t;
endpackage

// File: rtl/fbwr_datapath.sv
module fbwr_datapath
  import fbwr_pkg::*;
#(
  parameter int CMD_W      = 32,
  parameter int CMD_DEPTH  = 16,
  parameter int DATA_W     = 32,
  parameter int DATA_DEPTH = 128,
  localparam int CAW   = $clog2(CMD_DEPTH),
  localparam int CCW   = CAW + 1,
  localparam int DAW   = $clog2(DATA_DEPTH),
  localparam int DCW   = DAW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [CMD_W-1:0]  cmdIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataEobIn,
  output logic [CCW-1:0]    cmdCount,
  output logic [CMD_W-1:0]  cmdHeadWord,
  output logic              cmdHeadLast,
  output logic              cmdHasLast,
  output logic [DCW-1:0]    dataCount,
  output logic              dataHasEob,
  output logic [DATA_W-1:0] dataHead,
  output logic              dataHeadEob
);
  logic [CMD_W:0]  cmdMem  [CMD_DEPTH];
  logic [DATA_W:0] dataMem [DATA_DEPTH];
  logic [CAW-1:0]  cmdRd, cmdWr;
  logic [DAW-1:0]  dataRd, dataWr;
  logic [DCW-1:0]  eobCount;
  logic [CCW-1:0]  dropN;
  logic [CAW-1:0]  pos;

  // Distance from the head to the first last-tagged word, inclusive.
  always_comb begin
    dropN      = cmdCount;
    cmdHasLast = 1'b0;
    pos        = '0;
    for (int i = CMD_DEPTH - 1; i >= 0; i--) begin
      pos = cmdRd + CAW'(i);
      if (CCW'(i) < cmdCount && cmdMem[pos][CMD_W]) begin
        dropN      = CCW'(i + 1);
        cmdHasLast = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.cmdPush)  cmdMem[cmdWr]   <= {stb.cmdTag, cmdIn};
    if (stb.dataPush) dataMem[dataWr] <= {dataEobIn, dataIn};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdRd <= '0; cmdWr <= '0; cmdCount <= '0;
      dataRd <= '0; dataWr <= '0; dataCount <= '0; eobCount <= '0;
    end else begin
      if (stb.cmdPush) cmdWr <= cmdWr + 1'b1;
      cmdRd <= cmdRd + CAW'(stb.cmdPop) + (stb.cmdDrop ? dropN[CAW-1:0] : '0);
      cmdCount <= cmdCount + CCW'(stb.cmdPush) - CCW'(stb.cmdPop)
                  - (stb.cmdDrop ? dropN : '0);
      if (stb.dataClear) begin
        dataRd <= '0; dataWr <= '0; dataCount <= '0; eobCount <= '0;
      end else begin
        if (stb.dataPush) dataWr <= dataWr + 1'b1;
        if (stb.dataPop)  dataRd <= dataRd + 1'b1;
        dataCount <= dataCount + DCW'(stb.dataPush) - DCW'(stb.dataPop);
        eobCount  <= eobCount + DCW'(stb.dataPush && dataEobIn)
                     - DCW'(stb.dataPop && dataHeadEob);
      end
    end
  end

  assign cmdHeadWord = cmdMem[cmdRd][CMD_W-1:0];
  assign cmdHeadLast = cmdMem[cmdRd][CMD_W];
  assign dataHead    = dataMem[dataRd][DATA_W-1:0];
  assign dataHeadEob = dataMem[dataRd][DATA_W];
  assign dataHasEob  = (eobCount != '0);
endmodule

// File: rtl/fbwr_ctrl.sv
module fbwr_ctrl
  import fbwr_pkg::*;
#(
  parameter int CMD_DEPTH  = 16,
  parameter int AFULL_CNT  = 12,
  parameter int CMD_WORDS  = 4,
  parameter int DATA_DEPTH = 128,
  parameter int BURST_LEN  = 32,
  localparam int CCW = $clog2(CMD_DEPTH) + 1,
  localparam int DCW = $clog2(DATA_DEPTH) + 1,
  localparam int IW  = $clog2(CMD_WORDS),
  localparam int BW  = $clog2(BURST_LEN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmdWrite,
  input  logic           cmdEnd,
  input  logic           wdReset,
  input  logic           wdFlush,
  input  logic           wdWrite,
  input  logic           cmdOutPop,
  input  logic           rdPop,
  input  logic [CCW-1:0] cmdCount,
  input  logic           cmdHasLast,
  input  logic [DCW-1:0] dataCount,
  input  logic           dataHasEob,
  input  logic           dataHeadEob,
  output strobe_t        stb,
  output logic           cmdFull,
  output logic           cmdAlmostFull,
  output logic           cmdIdle,
  output logic           cmdOutValid,
  output logic           rdReady,
  output logic           rdLast,
  output logic           cmdOverflow,
  output logic           wdOverflow
);
  logic [IW-1:0] wordIdx;
  logic [BW-1:0] beatCnt;
  logic skipRest, burstActive;
  logic isLast, dropAll, skipNow, dataFull, clearNow;

  assign isLast   = (wordIdx == IW'(CMD_WORDS - 1)) || (wordIdx == IW'(1) && cmdEnd);
  assign dropAll  = wdReset && !cmdHasLast &&
                    (cmdCount != '0 || wordIdx != '0 || skipRest);
  assign skipNow  = skipRest || dropAll;
  assign cmdFull  = (cmdCount == CCW'(CMD_DEPTH));
  assign cmdAlmostFull = (cmdCount >= CCW'(AFULL_CNT));
  assign cmdOutValid   = (cmdCount != '0);
  assign cmdIdle  = !cmdOutValid && wordIdx == '0 && !skipRest;
  assign dataFull = (dataCount == DCW'(DATA_DEPTH));
  assign clearNow = wdFlush || wdReset;
  assign rdReady  = burstActive || dataCount >= DCW'(BURST_LEN) || dataHasEob;
  assign rdLast   = rdReady && (dataHeadEob || beatCnt == BW'(BURST_LEN - 1));

  always_comb begin
    stb.cmdPush   = cmdWrite && !skipNow && !cmdFull;
    stb.cmdTag    = isLast;
    stb.cmdPop    = cmdOutPop && cmdOutValid && !wdReset;
    stb.cmdDrop   = wdReset && cmdOutValid;
    stb.dataClear = clearNow;
    stb.dataPush  = wdWrite && !clearNow && !dataFull;
    stb.dataPop   = rdPop && rdReady && dataCount != '0 && !clearNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordIdx <= '0; skipRest <= 1'b0; burstActive <= 1'b0; beatCnt <= '0;
      cmdOverflow <= 1'b0; wdOverflow <= 1'b0;
    end else begin
      if (cmdWrite && (skipNow || !cmdFull))
        wordIdx <= isLast ? '0 : wordIdx + 1'b1;
      skipRest <= skipNow && !(cmdWrite && isLast);
      if (cmdWrite && !skipNow && cmdFull) cmdOverflow <= 1'b1;
      if (wdWrite && !clearNow && dataFull) wdOverflow <= 1'b1;
      if (clearNow) begin
        burstActive <= 1'b0; beatCnt <= '0;
      end else if (stb.dataPop) begin
        burstActive <= !rdLast;
        beatCnt     <= rdLast ? '0 : beatCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbwr_front.sv
module fbwr_front
  import fbwr_pkg::*;
#(
  parameter int CMD_DEPTH  = 16,
  parameter int AFULL_CNT  = 12,
  parameter int CMD_WORDS  = 4,
  parameter int DATA_W     = 32,
  parameter int DATA_DEPTH = 128,
  parameter int BURST_LEN  = 32,
  localparam int CCW = $clog2(CMD_DEPTH) + 1,
  localparam int DCW = $clog2(DATA_DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [31:0]         cmdData,
  input  logic                cmdWrite,
  input  logic                cmdEnd,
  output logic                cmdFull,
  output logic                cmdAlmostFull,
  output logic                cmdIdle,
  input  logic                wdReset,
  input  logic                wdFlush,
  input  logic                wdWrite,
  input  logic [DATA_W-1:0]   wdData,
  input  logic [DATA_W/8-1:0] wdByteEn,
  input  logic                wdEndBurst,
  output logic                cmdOutValid,
  output logic [31:0]         cmdOutData,
  output logic                cmdOutLast,
  input  logic                cmdOutPop,
  output logic                rdReady,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdLast,
  input  logic                rdPop,
  output logic                cmdOverflow,
  output logic                wdOverflow
);
  strobe_t        stb;
  logic [CCW-1:0] cmdCount;
  logic [DCW-1:0] dataCount;
  logic           cmdHasLast, dataHasEob, dataHeadEob;
  logic           unusedByteEn;

  assign unusedByteEn = ^wdByteEn;

  fbwr_ctrl #(
    .CMD_DEPTH(CMD_DEPTH), .AFULL_CNT(AFULL_CNT), .CMD_WORDS(CMD_WORDS),
    .DATA_DEPTH(DATA_DEPTH), .BURST_LEN(BURST_LEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmdWrite(cmdWrite), .cmdEnd(cmdEnd),
    .wdReset(wdReset), .wdFlush(wdFlush), .wdWrite(wdWrite),
    .cmdOutPop(cmdOutPop), .rdPop(rdPop), .cmdCount(cmdCount),
    .cmdHasLast(cmdHasLast), .dataCount(dataCount), .dataHasEob(dataHasEob),
    .dataHeadEob(dataHeadEob), .stb(stb), .cmdFull(cmdFull),
    .cmdAlmostFull(cmdAlmostFull), .cmdIdle(cmdIdle), .cmdOutValid(cmdOutValid),
    .rdReady(rdReady), .rdLast(rdLast), .cmdOverflow(cmdOverflow),
    .wdOverflow(wdOverflow)
  );

  fbwr_datapath #(
    .CMD_W(32), .CMD_DEPTH(CMD_DEPTH), .DATA_W(DATA_W), .DATA_DEPTH(DATA_DEPTH)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .cmdIn(cmdData), .dataIn(wdData),
    .dataEobIn(wdEndBurst), .cmdCount(cmdCount), .cmdHeadWord(cmdOutData),
    .cmdHeadLast(cmdOutLast), .cmdHasLast(cmdHasLast), .dataCount(dataCount),
    .dataHasEob(dataHasEob), .dataHead(rdData), .dataHeadEob(dataHeadEob)
  );
endmodule

// File: rtl/fbwr_front_chk.sv
module fbwr_front_chk (
  input logic clk,
  input logic rst,
  input logic wdReset,
  input logic wdFlush,
  input logic rdPop,
  input logic cmdOutPop,
  input logic cmdFull,
  input logic cmdAlmostFull,
  input logic cmdIdle,
  input logic cmdOutValid,
  input logic rdReady,
  input logic rdLast,
  input logic cmdOverflow,
  input logic wdOverflow
);
  // R3: a full queue is also above the almost-full threshold
  a_r3_full_implies_afull: assert property (@(posedge clk) disable iff (rst)
    cmdFull |-> cmdAlmostFull);
  // R4: idle never coexists with a queued command word
  a_r4_idle_empty: assert property (@(posedge clk) disable iff (rst)
    cmdIdle |-> !cmdOutValid);
  // R10: overflow flags are sticky
  a_r10_cmd_sticky: assert property (@(posedge clk) disable iff (rst)
    cmdOverflow |=> cmdOverflow);
  a_r10_wd_sticky: assert property (@(posedge clk) disable iff (rst)
    wdOverflow |=> wdOverflow);
  // R7: flush keeps queued commands
  a_r7_flush_keeps_cmd: assert property (@(posedge clk) disable iff (rst)
    (wdFlush && !wdReset && cmdOutValid && !cmdOutPop) |=> cmdOutValid);
  // R6: a started burst stays offered until its last word
  a_r6_burst_holds: assert property (@(posedge clk) disable iff (rst)
    (rdReady && rdPop && !rdLast && !wdFlush && !wdReset) |=> rdReady);
  // R8: clearing the data queue withdraws any burst
  a_r8_clear_drains: assert property (@(posedge clk) disable iff (rst)
    (wdFlush || wdReset) |=> !rdReady);
endmodule

bind fbwr_front fbwr_front_chk u_chk (
  .clk(clk), .rst(rst), .wdReset(wdReset), .wdFlush(wdFlush), .rdPop(rdPop),
  .cmdOutPop(cmdOutPop), .cmdFull(cmdFull), .cmdAlmostFull(cmdAlmostFull),
  .cmdIdle(cmdIdle), .cmdOutValid(cmdOutValid), .rdReady(rdReady),
  .rdLast(rdLast), .cmdOverflow(cmdOverflow), .wdOverflow(wdOverflow)
);

// File: tb/fbwr_front_tb.sv
module fbwr_front_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] cmdData = '0;
  logic cmdWrite = 0, cmdEnd = 0, cmdOutPop = 0;
  logic wdReset = 0, wdFlush = 0, wdWrite = 0, wdEndBurst = 0, rdPop = 0;
  logic [31:0] wdData = '0;
  logic [3:0]  wdByteEn = '0;
  logic cmdFull, cmdAlmostFull, cmdIdle, cmdOutValid, cmdOutLast;
  logic rdReady, rdLast, cmdOverflow, wdOverflow;
  logic [31:0] cmdOutData, rdData;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fbwr_front #(
    .CMD_DEPTH(8), .AFULL_CNT(6), .CMD_WORDS(4), .DATA_W(32),
    .DATA_DEPTH(64), .BURST_LEN(32)
  ) u_dut (
    .clk(clk), .rst(rst), .cmdData(cmdData), .cmdWrite(cmdWrite), .cmdEnd(cmdEnd),
    .cmdFull(cmdFull), .cmdAlmostFull(cmdAlmostFull), .cmdIdle(cmdIdle),
    .wdReset(wdReset), .wdFlush(wdFlush), .wdWrite(wdWrite), .wdData(wdData),
    .wdByteEn(wdByteEn), .wdEndBurst(wdEndBurst), .cmdOutValid(cmdOutValid),
    .cmdOutData(cmdOutData), .cmdOutLast(cmdOutLast), .cmdOutPop(cmdOutPop),
    .rdReady(rdReady), .rdData(rdData), .rdLast(rdLast), .rdPop(rdPop),
    .cmdOverflow(cmdOverflow), .wdOverflow(wdOverflow)
  );

  // {cmdEnd, expected full, expected almost-full, expected last tag}
  localparam logic [3:0] VEC [8] = '{
    4'b1000, 4'b0000, 4'b0000, 4'b0001,
    4'b0000, 4'b1011, 4'b0010, 4'b0110
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pushCmd(input logic [31:0] d, input logic e);
    cmdData = d; cmdEnd = e; cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0; cmdEnd = 1'b0;
  endtask

  task automatic popCmd();
    cmdOutPop = 1'b1;
    @(negedge clk);
    cmdOutPop = 1'b0;
  endtask

  task automatic pushData(input logic [31:0] d, input logic eob, input logic [3:0] be);
    wdData = d; wdEndBurst = eob; wdByteEn = be; wdWrite = 1'b1;
    @(negedge clk);
    wdWrite = 1'b0; wdEndBurst = 1'b0;
  endtask

  task automatic popData();
    rdPop = 1'b1;
    @(negedge clk);
    rdPop = 1'b0;
  endtask

  task automatic pulse(input logic isFlush);
    if (isFlush) wdFlush = 1'b1; else wdReset = 1'b1;
    @(negedge clk);
    wdFlush = 1'b0; wdReset = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1 idle", cmdIdle, 1);
    chk("R1 full", cmdFull, 0);
    chk("R1 afull", cmdAlmostFull, 0);
    chk("R1 cmdValid", cmdOutValid, 0);
    chk("R1 rdReady", rdReady, 0);
    chk("R1 overflow", {cmdOverflow, wdOverflow}, 0);

    // R3 R5: table walk filling the command queue
    for (int i = 0; i < 8; i++) begin
      pushCmd(32'hC0DE_0000 + i, VEC[i][3]);
      chk("R3 full", cmdFull, VEC[i][2]);
      chk("R3 afull", cmdAlmostFull, VEC[i][1]);
      chk("R4 busy", cmdIdle, 0);
    end
    // R10: push into full queue is lost
    pushCmd(32'hDEAD_DEAD, 1'b0);
    chk("R10 cmdOverflow", cmdOverflow, 1);
    chk("R10 still full", cmdFull, 1);
    // R2 R5: order and last tags (cmdEnd on index 0 ignored, index 1 honoured)
    for (int i = 0; i < 8; i++) begin
      chk("R2 order", cmdOutData, 32'hC0DE_0000 + i);
      chk("R5 last tag", cmdOutLast, VEC[i][0]);
      popCmd();
    end
    chk("R2 drained", cmdOutValid, 0);
    chk("R4 partial command not idle", cmdIdle, 0);
    pushCmd(32'hC0DE_0008, 1'b1);  // index 2: cmdEnd ignored
    pushCmd(32'hC0DE_0009, 1'b0);
    chk("R5 idx2 not last", cmdOutLast, 0);
    popCmd();
    chk("R5 idx3 last", cmdOutLast, 1);
    popCmd();
    chk("R4 idle after complete", cmdIdle, 1);

    // R8: reset with one complete command and a partial one queued
    doReset();
    for (int i = 0; i < 4; i++) pushCmd(32'hD000_0000 + i, 1'b0);
    pushCmd(32'hE000_0000, 1'b0);
    pushCmd(32'hE000_0001, 1'b0);
    pulse(1'b0);
    chk("R8 head dropped", cmdOutData, 32'hE000_0000);
    chk("R8 rest kept", cmdOutValid, 1);
    pulse(1'b0);
    chk("R8 partial dropped", cmdOutValid, 0);
    chk("R8 skipping not idle", cmdIdle, 0);
    pushCmd(32'hE000_0002, 1'b0);
    pushCmd(32'hE000_0003, 1'b0);
    chk("R8 rest discarded", cmdOutValid, 0);
    chk("R8 idle after discard", cmdIdle, 1);
    pushCmd(32'hF000_0000, 1'b0);
    chk("R8 next command kept", cmdOutData, 32'hF000_0000);

    // R6 R9: full burst
    doReset();
    for (int i = 0; i < 31; i++) pushData(32'hA000_0000 + i, 1'b0, 4'(i));
    chk("R6 not ready at 31", rdReady, 0);
    pushData(32'hA000_001F, 1'b0, 4'h0);
    chk("R6 ready at 32", rdReady, 1);
    for (int i = 0; i < 32; i++) begin
      chk("R9 data intact", rdData, 32'hA000_0000 + i);
      chk("R6 last at 32", rdLast, (i == 31));
      popData();
    end
    chk("R6 drained", rdReady, 0);
    // R6: short tagged burst
    for (int i = 0; i < 4; i++) pushData(32'hB000_0000 + i, 1'b0, 4'hF);
    chk("R6 short not ready", rdReady, 0);
    pushData(32'hB000_0004, 1'b1, 4'hF);
    chk("R6 tag ready", rdReady, 1);
    for (int i = 0; i < 5; i++) begin
      chk("R6 short data", rdData, 32'hB000_0000 + i);
      chk("R6 short last", rdLast, (i == 4));
      popData();
    end

    // R7: flush keeps command, clears data
    for (int i = 0; i < 4; i++) pushCmd(32'h6000_0000 + i, 1'b0);
    for (int i = 0; i < 3; i++) pushData(32'h7000_0000 + i, 1'b0, 4'h3);
    pulse(1'b1);
    chk("R7 command kept", cmdOutData, 32'h6000_0000);
    chk("R7 command valid", cmdOutValid, 1);
    pushData(32'hBEEF_0001, 1'b1, 4'h0);
    chk("R7 data cleared", rdData, 32'hBEEF_0001);
    chk("R7 tagged last", rdLast, 1);
    popData();
    // R8: reset drops complete command and data
    for (int i = 0; i < 2; i++) pushData(32'h7100_0000 + i, 1'b0, 4'h0);
    pulse(1'b0);
    chk("R8 command dropped", cmdOutValid, 0);
    chk("R8 idle", cmdIdle, 1);
    pushData(32'hCAFE_0001, 1'b1, 4'h0);
    chk("R8 data cleared", rdData, 32'hCAFE_0001);

    // R10: data overflow
    doReset();
    for (int i = 0; i < 64; i++) pushData(32'h5000_0000 + i, 1'b0, 4'h0);
    chk("R10 no wd overflow yet", wdOverflow, 0);
    pushData(32'hFFFF_FFFF, 1'b0, 4'h0);
    chk("R10 wdOverflow", wdOverflow, 1);
    chk("R10 head intact", rdData, 32'h5000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule